// File: doc/BRIEF.md
# ISP Serial Instruction Responder

This block is the target-side command engine for in-system programming over a four-wire serial slave port. While the programming-mode input is held high, an external programmer clocks four-byte instructions in on `mosi` with `sck`. The block decodes each instruction and applies it to an on-chip byte-wide program store with a 12-bit address. A returned byte is shifted out on `miso` in the slot the instruction defines. Two page instructions stream a whole 256-byte page after a two-byte header.

The serial pins are oversampled by the block clock through a synchronizer, so `sck` must be much slower than `clk`. The port works in SPI mode 0: the master changes `mosi` while `sck` is low and samples `miso` on the rising edge. The block moves `miso` only after a falling edge. A built-in synchronous RAM models the program store. Chip erase sweeps it with FFh, one address per clock.

Top module: `isp_target`

## Requirements
- R1: Bytes are assembled only while `prog_mode` is high. While it is low, the bit and byte counters are held at zero and the enabled state is cleared. Memory and lock state are kept.
- R2: Until a complete enable frame AC 53 xx xx has been received, every other instruction leaves memory and locks unchanged and returns 00h in all slots. During an enable frame the third byte slot returns 53h, whether or not the block is already enabled.
- R3: Write byte (40h, a, b, d) stores d at address {a[3:0], b}. Read byte (20h, a, b, x) returns the byte at {a[3:0], b} in the fourth byte slot.
- R4: AC with a second byte of the form 100xxxxx sets every location to FFh and clears all lock bits. The sweep takes 2^ADDR_W clock cycles.
- R5: AC with a second byte 111000vv raises the lock level to at least vv. Level 1 sets LB1, level 2 sets LB1 and LB2, and level 3 sets all three. Lock bits only accumulate. Read lock (24h) returns LB3, LB2 and LB1 in bits 4, 3 and 2 of the fourth slot, with all other bits zero.
- R6: With LB1 set, byte and page writes are ignored. With LB2 set, byte and page reads return FFh.
- R7: Read signature (28h, a, b, x) forms a six-bit index {a[4:0], b[7]}. Index 0 returns 1Eh, index 2 returns 51h and index 4 returns 06h. Any other index returns FFh. Lock bits have no effect on this instruction.
- R8: Page read (30h, p, …) returns byte i of page p[3:0] in byte slot i+2, for i = 0 to 255. The frame is 258 bytes long.
- R9: Page write (50h, p, d0..d255) stores the byte in slot i+2 at address {p[3:0], i}. It affects no other page.
- R10: Dropping `prog_mode` in the middle of a frame discards the partial frame. The next frame after the mode rises again is decoded from its first bit.
- R11: `miso` is 00h after reset and during the first byte slot of every frame. It changes only after a falling `sck` edge, or when the mode drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_mode | input | 1 | High to accept serial programming frames |
| sck | input | 1 | Serial clock from the programmer, idle low |
| mosi | input | 1 | Serial data in, MSB first |
| miso | output | 1 | Serial data out, MSB first |

## Verification
The hardest case to reach from the ports is a mode drop that lands partway through a byte in the middle of a write frame. If that leaves the counters out of step, later frames decode on the wrong bit and the write may even land. The stimulus stops a write frame after its third byte and four bits of the fourth, lowers the mode, and raises it again. It then shows that the block is no longer enabled, re-enables it, and reads the target address to confirm both that the old value is intact and that framing is aligned. The two 258-byte page frames are the other hard case: together they exercise the first and last offsets of a page and the clean return to four-byte framing.

// File: rtl/isp_pkg.sv
package isp_pkg;
   localparam logic [7:0] OP_SYS   = 8'hAC;
   localparam logic [7:0] OP_RD    = 8'h20;
   localparam logic [7:0] OP_WR    = 8'h40;
   localparam logic [7:0] OP_LKRD  = 8'h24;
   localparam logic [7:0] OP_SIG   = 8'h28;
   localparam logic [7:0] OP_PGRD  = 8'h30;
   localparam logic [7:0] OP_PGWR  = 8'h50;
   localparam logic [7:0] UNLOCK_KEY = 8'h53;

   typedef enum logic [1:0] {
      RS_ZERO,
      RS_CONST,
      RS_MEM
   } reply_src_t;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("isp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= st[g-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       sck_s,
   input  logic       mosi_s,
   input  logic       ld_vld,
   input  logic [7:0] ld_byte,
   output logic       byte_vld,
   output logic [7:0] byte_val,
   output logic       fall_evt,
   output logic       miso
);
   logic       sck_d;
   logic       rise_evt;
   logic [2:0] bit_cnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh;
   logic [7:0] tx_hold;
   logic       hold_full;

   assign rise_evt = sck_s & ~sck_d;
   assign fall_evt = ~sck_s & sck_d;
   assign miso     = tx_sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d     <= 1'b0;
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         tx_hold   <= '0;
         hold_full <= 1'b0;
         byte_vld  <= 1'b0;
         byte_val  <= '0;
      end else begin
         sck_d    <= sck_s;
         byte_vld <= 1'b0;
         if (clr) begin
            bit_cnt   <= '0;
            tx_sh     <= '0;
            hold_full <= 1'b0;
         end else begin
            if (rise_evt) begin
               rx_sh   <= {rx_sh[5:0], mosi_s};
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  byte_vld <= 1'b1;
                  byte_val <= {rx_sh, mosi_s};
               end
            end
            if (fall_evt) begin
               if (hold_full) begin
                  tx_sh     <= tx_hold;
                  hold_full <= 1'b0;
               end else begin
                  tx_sh <= {tx_sh[6:0], 1'b0};
               end
            end
            if (ld_vld) begin
               tx_hold   <= ld_byte;
               hold_full <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/isp_ram.sv
module isp_ram #(
   parameter int AW = 12,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
   end
endmodule

// File: rtl/isp_exec.sv
module isp_exec
   import isp_pkg::*;
#(
   parameter int          ADDR_W = 12,
   parameter logic [7:0]  SIG0   = 8'h1E,
   parameter logic [7:0]  SIG1   = 8'h51,
   parameter logic [7:0]  SIG2   = 8'h06
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_on,
   input  logic              byte_vld,
   input  logic [7:0]        byte_val,
   input  logic [7:0]        ram_rdata,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              ld_vld,
   output logic [7:0]        ld_byte,
   output logic              enabled,
   output logic [2:0]        lock_bits,
   output logic              erasing,
   output logic [8:0]        frame_idx
);
   localparam int          PG_W       = ADDR_W - 8;
   localparam int          PAGE_BYTES = 256;
   localparam logic [8:0]  LAST_PG    = 9'(PAGE_BYTES + 1);
   localparam logic [8:0]  LAST_STD   = 9'd3;

   logic [8:0]        idx;
   logic [7:0]        op, b1, b2;
   logic              en_q, ers_q;
   logic [2:0]        lock_q;
   logic [ADDR_W-1:0] ers_cnt;
   logic              pend;
   reply_src_t        rsel, n_rsel;
   logic [7:0]        rconst, n_rconst;
   logic              x_we;
   logic [ADDR_W-1:0] x_addr;
   logic              is_page, wr_ok, rd_ok;
   logic [8:0]        last_idx;
   logic [PG_W-1:0]   page_cur;

   function automatic logic [7:0] sig_lookup(input logic [5:0] ix);
      case (ix)
         6'd0:    return SIG0;
         6'd2:    return SIG1;
         6'd4:    return SIG2;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [2:0] lock_level(input logic [1:0] v);
      return {v == 2'd3, v >= 2'd2, v >= 2'd1};
   endfunction

   assign is_page  = (op == OP_PGRD) || (op == OP_PGWR);
   assign last_idx = is_page ? LAST_PG : LAST_STD;
   assign page_cur = (idx == 9'd1) ? byte_val[PG_W-1:0] : b1[PG_W-1:0];
   assign wr_ok    = en_q & ~lock_q[0] & ~ers_q;
   assign rd_ok    = ~lock_q[1];

   always_comb begin
      x_we     = 1'b0;
      x_addr   = '0;
      n_rsel   = RS_ZERO;
      n_rconst = '0;
      if (byte_vld && mode_on) begin
         if (idx == 9'd1 && op == OP_SYS && byte_val == UNLOCK_KEY) begin
            n_rsel   = RS_CONST;
            n_rconst = UNLOCK_KEY;
         end else if (en_q) begin
            if (is_page) begin
               if (op == OP_PGRD && idx != 9'd0 && idx != LAST_PG) begin
                  x_addr   = {page_cur, idx[7:0] - 8'd1};
                  n_rsel   = rd_ok ? RS_MEM : RS_CONST;
                  n_rconst = 8'hFF;
               end
               if (op == OP_PGWR && idx >= 9'd2) begin
                  x_addr = {page_cur, idx[7:0] - 8'd2};
                  x_we   = wr_ok;
               end
            end else if (idx == 9'd2) begin
               case (op)
                  OP_RD: begin
                     x_addr   = {b1[PG_W-1:0], byte_val};
                     n_rsel   = rd_ok ? RS_MEM : RS_CONST;
                     n_rconst = 8'hFF;
                  end
                  OP_LKRD: begin
                     n_rsel   = RS_CONST;
                     n_rconst = {3'b000, lock_q, 2'b00};
                  end
                  OP_SIG: begin
                     n_rsel   = RS_CONST;
                     n_rconst = sig_lookup({b1[4:0], byte_val[7]});
                  end
                  default: ;
               endcase
            end else if (idx == 9'd3 && op == OP_WR) begin
               x_addr = {b1[PG_W-1:0], b2};
               x_we   = wr_ok;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx     <= '0;
         op      <= '0;
         b1      <= '0;
         b2      <= '0;
         en_q    <= 1'b0;
         ers_q   <= 1'b0;
         lock_q  <= '0;
         ers_cnt <= '0;
         pend    <= 1'b0;
         rsel    <= RS_ZERO;
         rconst  <= '0;
      end else begin
         pend <= 1'b0;
         if (ers_q) begin
            ers_cnt <= ers_cnt + 1'b1;
            if (ers_cnt == {ADDR_W{1'b1}}) ers_q <= 1'b0;
         end
         if (!mode_on) begin
            idx  <= '0;
            en_q <= 1'b0;
         end else if (byte_vld) begin
            if (idx != 9'd0 && idx == last_idx) idx <= '0;
            else                                 idx <= idx + 9'd1;
            case (idx)
               9'd0:    op <= byte_val;
               9'd1:    b1 <= byte_val;
               9'd2:    b2 <= byte_val;
               default: ;
            endcase
            pend   <= 1'b1;
            rsel   <= n_rsel;
            rconst <= n_rconst;
            if (idx == 9'd3 && !is_page && op == OP_SYS) begin
               if (b1 == UNLOCK_KEY) begin
                  en_q <= 1'b1;
               end else if (en_q && !ers_q && b1[7:5] == 3'b100) begin
                  ers_q   <= 1'b1;
                  ers_cnt <= '0;
                  lock_q  <= '0;
               end else if (en_q && !ers_q && b1[7:2] == 6'b111000) begin
                  lock_q <= lock_q | lock_level(b1[1:0]);
               end
            end
         end
      end
   end

   always_comb begin
      case (rsel)
         RS_MEM:   ld_byte = ram_rdata;
         RS_CONST: ld_byte = rconst;
         default:  ld_byte = 8'h00;
      endcase
   end

   assign ld_vld    = pend;
   assign ram_we    = ers_q | x_we;
   assign ram_addr  = ers_q ? ers_cnt : x_addr;
   assign ram_wdata = ers_q ? 8'hFF : byte_val;
   assign enabled   = en_q;
   assign lock_bits = lock_q;
   assign erasing   = ers_q;
   assign frame_idx = idx;
endmodule

// File: rtl/isp_target.sv
module isp_target #(
   parameter int         ADDR_W      = 12,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] SIG0        = 8'h1E,
   parameter logic [7:0] SIG1        = 8'h51,
   parameter logic [7:0] SIG2        = 8'h06
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prog_mode,
   input  logic sck,
   input  logic mosi,
   output logic miso
);
   if (ADDR_W < 9 || ADDR_W > 12) begin : g_bad_addr
      $error("isp_target: ADDR_W must lie in 9..12");
   end

   logic [2:0]        pins_s;
   logic              mode_s, sck_s, mosi_s;
   logic              byte_vld, ld_vld, fall_w;
   logic [7:0]        byte_val, ld_byte;
   logic              ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [7:0]        ram_wdata, ram_rdata;
   logic              en_w, ers_w;
   logic [2:0]        lock_w;
   logic [8:0]        idx_w;

   isp_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({prog_mode, sck, mosi}),
      .q     (pins_s)
   );
   assign {mode_s, sck_s, mosi_s} = pins_s;

   isp_shifter u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~mode_s),
      .sck_s    (sck_s),
      .mosi_s   (mosi_s),
      .ld_vld   (ld_vld),
      .ld_byte  (ld_byte),
      .byte_vld (byte_vld),
      .byte_val (byte_val),
      .fall_evt (fall_w),
      .miso     (miso)
   );

   isp_exec #(.ADDR_W(ADDR_W), .SIG0(SIG0), .SIG1(SIG1), .SIG2(SIG2)) u_exec (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_on   (mode_s),
      .byte_vld  (byte_vld),
      .byte_val  (byte_val),
      .ram_rdata (ram_rdata),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .ld_vld    (ld_vld),
      .ld_byte   (ld_byte),
      .enabled   (en_w),
      .lock_bits (lock_w),
      .erasing   (ers_w),
      .frame_idx (idx_w)
   );

   isp_ram #(.AW(ADDR_W), .DW(8)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );
endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_s,
   input logic       enabled,
   input logic [2:0] lock_bits,
   input logic       erasing,
   input logic [8:0] frame_idx,
   input logic       ram_we,
   input logic       fall_evt,
   input logic       miso
);
   // R1
   mode_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_s |=> (!enabled && frame_idx == 9'd0));

   // R2
   write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !erasing) |-> enabled);

   // R6
   write_blocked_by_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !erasing) |-> !lock_bits[0]);

   // R4
   erase_clears_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(erasing) |-> (lock_bits == 3'b000));

   // R11
   miso_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso) |-> ($past(fall_evt) || !$past(mode_s)));
endmodule

bind isp_target isp_target_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_s    (mode_s),
   .enabled   (en_w),
   .lock_bits (lock_w),
   .erasing   (ers_w),
   .frame_idx (idx_w),
   .ram_we    (ram_we),
   .fall_evt  (fall_w),
   .miso      (miso)
);

// File: tb/isp_target_tb.sv
module isp_target_tb;
   logic clk = 1'b0;
   logic rst_n, prog_mode, sck, mosi;
   logic miso;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   bit         q_chk [$];
   logic [7:0] q_exp [$];
   string      q_tag [$];
   logic [7:0] rx_got;
   event       byte_ev;

   always #10 clk = ~clk;

   isp_target u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_mode (prog_mode),
      .sck       (sck),
      .mosi      (mosi),
      .miso      (miso)
   );

   function automatic logic [7:0] pdat(input int i, input logic [7:0] seed);
      return 8'((i * 7 + 3) & 255) ^ seed;
   endfunction

   task automatic wrap_up();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic half();
      repeat (8) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         mosi = b[i];
         half();
         sck = 1'b1;
         half();
         sck = 1'b0;
      end
   endtask

   // Driver: pushes the expected reply, then shifts one byte and publishes it.
   task automatic xb(input logic [7:0] b, input bit chk, input logic [7:0] exp, input string tag);
      logic [7:0] r;
      q_chk.push_back(chk);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      r = '0;
      for (int i = 7; i >= 0; i--) begin
         mosi = b[i];
         half();
         r = {r[6:0], miso};
         sck = 1'b1;
         half();
         sck = 1'b0;
      end
      rx_got = r;
      -> byte_ev;
   endtask

   task automatic cmd4(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [7:0] d, input int slot, input logic [7:0] exp,
                       input string tag);
      xb(a, slot == 0, exp, tag);
      xb(b, slot == 1, exp, tag);
      xb(c, slot == 2, exp, tag);
      xb(d, slot == 3, exp, tag);
   endtask

   task automatic mode_cycle();
      prog_mode = 1'b0;
      repeat (6) @(negedge clk);
      prog_mode = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   // Monitor: pops one expectation per received byte.
   initial begin
      forever begin
         @(byte_ev);
         if (q_chk.size() > 0) begin
            bit         c;
            logic [7:0] e;
            string      t;
            c = q_chk.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            if (c) begin
               total++;
               if (rx_got !== e) begin
                  bad++;
                  $display("FAIL %s: got %02h expected %02h", t, rx_got, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got running expected finished");
      wrap_up();
   end

   initial begin
      rst_n = 1'b0; prog_mode = 1'b0; sck = 1'b0; mosi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      total++;
      if (miso !== 1'b0) begin
         bad++;
         $display("FAIL R11 reset: got %b expected 0", miso);
      end
      prog_mode = 1'b1;
      repeat (4) @(negedge clk);

      // enable, erase, then leave the mode to drop the enable state
      cmd4(8'hAC, 8'h53, 8'h00, 8'h00, 2, 8'h53, "R2 enable echo");
      cmd4(8'hAC, 8'h80, 8'h00, 8'h00, -1, 8'h00, "R4");
      repeat (4200) @(negedge clk);
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'hFF, "R4 erased byte");
      cmd4(8'h20, 8'h0F, 8'hFF, 8'h00, 3, 8'hFF, "R4 erased top byte");
      mode_cycle();
      cmd4(8'h40, 8'h01, 8'h23, 8'h77, -1, 8'h00, "R2");
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'h00, "R1 enable cleared by mode drop");
      cmd4(8'hAC, 8'h53, 8'h00, 8'h00, 2, 8'h53, "R2 echo again");
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'hFF, "R2 write before enable ignored");

      // byte write and read
      cmd4(8'h40, 8'h01, 8'h23, 8'hA5, -1, 8'h00, "R3");
      cmd4(8'h40, 8'h0F, 8'h00, 8'h3C, -1, 8'h00, "R3");
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'hA5, "R3 read back");
      cmd4(8'h20, 8'h0F, 8'h00, 8'h00, 3, 8'h3C, "R3 high nibble address");
      cmd4(8'h20, 8'h00, 8'h23, 8'h00, 3, 8'hFF, "R3 other nibble untouched");
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 0, 8'h00, "R11 first slot zero");

      // signature and lock read
      cmd4(8'h28, 8'h00, 8'h00, 8'h00, 3, 8'h1E, "R7 index 0");
      cmd4(8'h28, 8'h01, 8'h00, 8'h00, 3, 8'h51, "R7 index 2");
      cmd4(8'h28, 8'h02, 8'h00, 8'h00, 3, 8'h06, "R7 index 4");
      cmd4(8'h28, 8'h03, 8'h00, 8'h00, 3, 8'hFF, "R7 index 6");
      cmd4(8'h24, 8'h00, 8'h00, 8'h00, 3, 8'h00, "R5 no locks");

      // page write then page read
      xb(8'h50, 1'b0, 8'h00, "R9");
      xb(8'h02, 1'b0, 8'h00, "R9");
      for (int i = 0; i < 256; i++) xb(pdat(i, 8'h5A), 1'b0, 8'h00, "R9");
      cmd4(8'h20, 8'h02, 8'h00, 8'h00, 3, pdat(0, 8'h5A), "R9 page first byte");
      cmd4(8'h20, 8'h02, 8'hFF, 8'h00, 3, pdat(255, 8'h5A), "R9 page last byte");
      cmd4(8'h20, 8'h03, 8'h00, 8'h00, 3, 8'hFF, "R9 next page untouched");
      xb(8'h30, 1'b0, 8'h00, "R8");
      xb(8'h02, 1'b0, 8'h00, "R8");
      for (int i = 0; i < 256; i++) xb(8'h00, 1'b1, pdat(i, 8'h5A), "R8 page stream");
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'hA5, "R8 framing after page");

      // mid-frame mode drop
      xb(8'h40, 1'b0, 8'h00, "R10");
      xb(8'h01, 1'b0, 8'h00, "R10");
      xb(8'h23, 1'b0, 8'h00, "R10");
      send_bits(8'h00, 4);
      mode_cycle();
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'h00, "R1 not enabled after drop");
      cmd4(8'hAC, 8'h53, 8'h00, 8'h00, 2, 8'h53, "R10 enable aligned");
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'hA5, "R10 partial write discarded");

      // locks
      cmd4(8'hAC, 8'hE1, 8'h00, 8'h00, -1, 8'h00, "R5");
      cmd4(8'h24, 8'h00, 8'h00, 8'h00, 3, 8'h04, "R5 level 1");
      cmd4(8'h40, 8'h01, 8'h23, 8'h00, -1, 8'h00, "R6");
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'hA5, "R6 write blocked");
      cmd4(8'hAC, 8'hE2, 8'h00, 8'h00, -1, 8'h00, "R5");
      cmd4(8'h24, 8'h00, 8'h00, 8'h00, 3, 8'h0C, "R5 level 2");
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'hFF, "R6 read hidden");
      cmd4(8'h28, 8'h00, 8'h00, 8'h00, 3, 8'h1E, "R7 signature under lock");

      // erase clears locks
      cmd4(8'hAC, 8'h80, 8'h00, 8'h00, -1, 8'h00, "R4");
      repeat (4200) @(negedge clk);
      cmd4(8'h24, 8'h00, 8'h00, 8'h00, 3, 8'h00, "R4 locks cleared");
      cmd4(8'h20, 8'h01, 8'h23, 8'h00, 3, 8'hFF, "R4 data erased");

      repeat (20) @(negedge clk);
      wrap_up();
   end
endmodule